// File: doc/BRIEF.md
# Delta-Sigma Bitstream Density Range Monitor

This block watches the one-bit output of a delta-sigma modulator and measures how many of its bits are 1 over a window of fixed length. The ratio of ones to the window length maps to input amplitude: half ones is zero input, 86% ones is positive full scale, and 14% ones is negative full scale. The loop still tolerates overdrive up to 93% or down to 7% ones. Past those points the modulator may oscillate.

At the end of every window the block publishes the raw ones count and a two-bit range class. If the class is unstable, it latches an error flag. A supervisor reads the class to see that a modulator is being driven hard. It pulses the clear input to acknowledge the flag, and this also restarts the window being collected. The window length is a power of two. Thresholds are integer counts derived from the percentage parameters when the design is elaborated. A parameter picks between non-overlapping block windows and a sliding window that reports on every bit once it is full.

Top module: `dsm_density_monitor`

## Requirements
- R1: After reset the ones count reads WIN/2 (512 with the default WIN of 1024), the class reads 00, and both the window-done pulse and the error flag are low.
- R2: In block mode a window is exactly WIN bits with bit_valid_i high; bits with bit_valid_i low are ignored. On the clock edge that accepts the last bit, ones_cnt_o takes the number of 1 bits in the window and win_done_o goes high for exactly one cycle.
- R3: Let HI_FS = floor(WIN*86/100) (880) and LO_FS = WIN-HI_FS (144). The class is 00 (in range) when LO_FS <= count <= HI_FS.
- R4: Let HI_OVR = floor(WIN*93/100) (952). The class is 01 (positive over-range) when HI_FS < count <= HI_OVR.
- R5: Let LO_OVR = WIN-HI_OVR (72). The class is 10 (negative over-range) when LO_OVR <= count < LO_FS.
- R6: The class is 11 (unstable) when count > HI_OVR or count < LO_OVR.
- R7: The error flag rises on the clock edge after a window reports class 11. It then stays high through any number of later in-range windows.
- R8: A one-cycle pulse on clr_i lowers the error flag on the next edge and discards any bits collected for the current window. A clear that coincides with the window-done cycle of an unstable window leaves the flag low.
- R9: Between window-done pulses, the ones count and class hold their values.
- R10: A window of all ones reports WIN, and a window of all zeros reports 0. Both are class 11, and neither wraps the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bit_i | input | 1 | Modulator bitstream |
| bit_valid_i | input | 1 | Marks bit_i as a sample to count |
| clr_i | input | 1 | Clears error flag and restarts the window |
| ones_cnt_o | output | WIN_LOG2+1 | Ones in the last completed window |
| status_o | output | 2 | Range class: 00 in, 01 pos over, 10 neg over, 11 unstable |
| win_done_o | output | 1 | One-cycle pulse when a window completes |
| err_o | output | 1 | Sticky unstable flag |

## Verification
The count, the class and the done pulse are all due on the same edge that accepts the last valid bit of a window. The bench drives on falling edges and reads them at the falling edge right after that bit. The error flag comes one edge later, so it is read at the following falling edge, which is also when the done pulse must be low again. A clear is judged one edge after it is applied. The effect of a clear on a partly collected window is judged from the count of the next full window.

// File: rtl/dsm_density_pkg.sv
package dsm_density_pkg;

   typedef enum logic [1:0] {
      RANGE_OK      = 2'b00,
      RANGE_POS_OVR = 2'b01,
      RANGE_NEG_OVR = 2'b10,
      RANGE_UNSTABLE = 2'b11
   } range_class_e;

   function automatic int unsigned pct_count(input int unsigned win, input int unsigned pct);
      return (win * pct) / 100;
   endfunction

endpackage

// File: rtl/dsm_win_counter.sv
module dsm_win_counter #(
   parameter int unsigned WIN_LOG2 = 10,
   parameter bit          SLIDING  = 1'b0
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                bit_i,
   input  logic                valid_i,
   input  logic                restart_i,
   output logic [WIN_LOG2:0]   cnt_o,
   output logic                done_o
);
   localparam int unsigned WIN = 1 << WIN_LOG2;
   localparam int unsigned CW  = WIN_LOG2 + 1;

   logic [CW-1:0] cnt_q;
   logic          done_q;

   if (!SLIDING) begin : g_block
      logic [CW-1:0]       acc_q;
      logic [WIN_LOG2-1:0] idx_q;

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            acc_q  <= '0;
            idx_q  <= '0;
            cnt_q  <= CW'(WIN / 2);
            done_q <= 1'b0;
         end else begin
            done_q <= 1'b0;
            if (restart_i) begin
               acc_q <= '0;
               idx_q <= '0;
            end else if (valid_i) begin
               if (&idx_q) begin
                  cnt_q  <= acc_q + CW'(bit_i);
                  done_q <= 1'b1;
                  acc_q  <= '0;
                  idx_q  <= '0;
               end else begin
                  acc_q <= acc_q + CW'(bit_i);
                  idx_q <= idx_q + 1'b1;
               end
            end
         end
      end

      AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         done_q |=> !done_q);  // R2
   end else begin : g_sliding
      logic [WIN-1:0] hist_q;
      logic [CW-1:0]  run_q;
      logic [CW-1:0]  fill_q;
      logic [CW-1:0]  run_nx;
      logic [CW-1:0]  fill_nx;
      logic           full;

      assign full    = (fill_q == CW'(WIN));
      assign fill_nx = full ? fill_q : fill_q + 1'b1;
      assign run_nx  = run_q + CW'(bit_i) - (full ? CW'(hist_q[WIN-1]) : '0);

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            hist_q <= '0;
            run_q  <= '0;
            fill_q <= '0;
            cnt_q  <= CW'(WIN / 2);
            done_q <= 1'b0;
         end else begin
            done_q <= 1'b0;
            if (restart_i) begin
               hist_q <= '0;
               run_q  <= '0;
               fill_q <= '0;
            end else if (valid_i) begin
               hist_q <= {hist_q[WIN-2:0], bit_i};
               run_q  <= run_nx;
               fill_q <= fill_nx;
               if (fill_nx == CW'(WIN)) begin
                  cnt_q  <= run_nx;
                  done_q <= 1'b1;
               end
            end
         end
      end
   end

   assign cnt_o  = cnt_q;
   assign done_o = done_q;

   AST_DONE_NEEDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_q |-> $past(valid_i && !restart_i));  // R2
   AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_q |-> $stable(cnt_q));  // R9
   AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CW'(WIN));  // R10

endmodule

// File: rtl/dsm_density_classify.sv
module dsm_density_classify
   import dsm_density_pkg::*;
#(
   parameter int unsigned CW     = 11,
   parameter int unsigned HI_FS  = 880,
   parameter int unsigned HI_OVR = 952,
   parameter int unsigned LO_FS  = 144,
   parameter int unsigned LO_OVR = 72
) (
   input  logic [CW-1:0] cnt_i,
   output range_class_e  class_o
);
   always_comb begin
      if (cnt_i > CW'(HI_OVR) || cnt_i < CW'(LO_OVR)) begin
         class_o = RANGE_UNSTABLE;
      end else if (cnt_i > CW'(HI_FS)) begin
         class_o = RANGE_POS_OVR;
      end else if (cnt_i < CW'(LO_FS)) begin
         class_o = RANGE_NEG_OVR;
      end else begin
         class_o = RANGE_OK;
      end
   end
endmodule

// File: rtl/dsm_sticky_flag.sv
module dsm_sticky_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     flag_q <= 1'b0;
      else if (clr_i)  flag_q <= 1'b0;
      else if (set_i)  flag_q <= 1'b1;
   end

   assign flag_o = flag_q;

   AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !clr_i) |=> flag_q);  // R7
   AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i && !clr_i) |=> flag_q);  // R7
   AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !flag_q);  // R8

endmodule

// File: rtl/dsm_density_monitor.sv
module dsm_density_monitor
   import dsm_density_pkg::*;
#(
   parameter int unsigned WIN_LOG2 = 10,
   parameter bit          SLIDING  = 1'b0,
   parameter int unsigned FS_PCT   = 86,
   parameter int unsigned OVR_PCT  = 93
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                bit_i,
   input  logic                bit_valid_i,
   input  logic                clr_i,
   output logic [WIN_LOG2:0]   ones_cnt_o,
   output logic [1:0]          status_o,
   output logic                win_done_o,
   output logic                err_o
);
   localparam int unsigned WIN    = 1 << WIN_LOG2;
   localparam int unsigned CW     = WIN_LOG2 + 1;
   localparam int unsigned HI_FS  = pct_count(WIN, FS_PCT);
   localparam int unsigned HI_OVR = pct_count(WIN, OVR_PCT);
   localparam int unsigned LO_FS  = WIN - HI_FS;
   localparam int unsigned LO_OVR = WIN - HI_OVR;

   if (WIN_LOG2 < 4 || WIN_LOG2 > 12) begin : g_bad_win
      $error("WIN_LOG2 must lie in 4..12");
   end
   if (FS_PCT <= 50 || OVR_PCT <= FS_PCT || OVR_PCT >= 100) begin : g_bad_pct
      $error("need 50 < FS_PCT < OVR_PCT < 100");
   end

   logic [CW-1:0] cnt;
   logic          done;
   range_class_e  cls;
   logic          unstable_hit;

   dsm_win_counter #(
      .WIN_LOG2 (WIN_LOG2),
      .SLIDING  (SLIDING)
   ) i_counter (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .bit_i     (bit_i),
      .valid_i   (bit_valid_i),
      .restart_i (clr_i),
      .cnt_o     (cnt),
      .done_o    (done)
   );

   dsm_density_classify #(
      .CW     (CW),
      .HI_FS  (HI_FS),
      .HI_OVR (HI_OVR),
      .LO_FS  (LO_FS),
      .LO_OVR (LO_OVR)
   ) i_classify (
      .cnt_i   (cnt),
      .class_o (cls)
   );

   assign unstable_hit = done && (cls == RANGE_UNSTABLE);

   dsm_sticky_flag i_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (unstable_hit),
      .clr_i  (clr_i),
      .flag_o (err_o)
   );

   assign ones_cnt_o = cnt;
   assign status_o   = cls;
   assign win_done_o = done;

   AST_CLASS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !win_done_o |-> $stable(status_o));  // R9
   AST_NO_ERR_WITHOUT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o) |-> $past(win_done_o && status_o == 2'b11));  // R7

endmodule

// File: tb/test_dsm_density_monitor.sv
module test_dsm_density_monitor;
   localparam int  CLK_PERIOD = 10;
   localparam int  WLOG = 10;
   localparam int  N = 1 << WLOG;
   localparam int  HI_FS = N * 86 / 100;
   localparam int  HI_OVR = N * 93 / 100;
   localparam int  LO_FS = N - HI_FS;
   localparam int  LO_OVR = N - HI_OVR;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_in = 1'b0;
   logic valid = 1'b0;
   logic clr = 1'b0;
   logic [WLOG:0] cnt;
   logic [1:0]    status;
   logic          done;
   logic          err;

   int tests = 0;
   int fails = 0;
   logic err_model = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dsm_density_monitor #(.WIN_LOG2(WLOG)) i_dsm_density_monitor (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bit_i       (bit_in),
      .bit_valid_i (valid),
      .clr_i       (clr),
      .ones_cnt_o  (cnt),
      .status_o    (status),
      .win_done_o  (done),
      .err_o       (err)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_class(input int c);
      if (c > HI_OVR || c < LO_OVR) return 3;
      if (c > HI_FS) return 1;
      if (c < LO_FS) return 2;
      return 0;
   endfunction

   // Feeds one window holding 'ones' 1-bits spread evenly; gaps insert
   // invalid cycles carrying bit=1; clr_end pulses clear in the done cycle.
   task automatic feed_window(input int ones, input bit gaps, input bit clr_end, input string req);
      int ec;
      for (int j = 0; j < N; j++) begin
         if (gaps && (j % 7 == 3)) begin
            @(negedge clk);
            valid  = 1'b0;
            bit_in = 1'b1;
         end
         @(negedge clk);
         valid  = 1'b1;
         bit_in = (((j + 1) * ones) / N) != ((j * ones) / N);
      end
      @(negedge clk);
      valid = 1'b0;
      bit_in = 1'b0;
      ec = exp_class(ones);
      chk({req, " done pulse R2"}, int'(done), 1);
      chk({req, " count R2"}, int'(cnt), ones);
      chk({req, " class"}, int'(status), ec);
      clr = clr_end;
      err_model = clr_end ? 1'b0 : (err_model | (ec == 3));
      @(negedge clk);
      clr = 1'b0;
      chk({req, " done low R2"}, int'(done), 0);
      chk({req, " err R7"}, int'(err), int'(err_model));
   endtask

   task automatic t_reset;
      chk("R1 count", int'(cnt), N / 2);
      chk("R1 class", int'(status), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 err", int'(err), 0);
   endtask

   task automatic t_in_range;
      feed_window(N / 2, 1'b0, 1'b0, "R3 mid");
      feed_window(HI_FS, 1'b0, 1'b0, "R3 upper edge");
      feed_window(LO_FS, 1'b1, 1'b0, "R3 lower edge with gaps R2");
   endtask

   task automatic t_pos_over;
      feed_window(HI_FS + 1, 1'b0, 1'b0, "R4 just over");
      feed_window(HI_OVR, 1'b0, 1'b0, "R4 at limit");
   endtask

   task automatic t_neg_over;
      feed_window(LO_FS - 1, 1'b0, 1'b0, "R5 just under");
      feed_window(LO_OVR, 1'b0, 1'b0, "R5 at limit");
   endtask

   task automatic t_unstable_sticky;
      feed_window(HI_OVR + 1, 1'b0, 1'b0, "R6 pos beyond");
      chk("R7 flag set", int'(err), 1);
      feed_window(N / 2, 1'b0, 1'b0, "R7 sticky window");
      chk("R7 flag held", int'(err), 1);
   endtask

   task automatic t_clear;
      // partial window then clear: bits before clear must not count
      for (int j = 0; j < 100; j++) begin
         @(negedge clk);
         valid = 1'b1;
         bit_in = 1'b1;
      end
      @(negedge clk);
      valid = 1'b0;
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      err_model = 1'b0;
      chk("R8 flag cleared", int'(err), 0);
      feed_window(LO_FS, 1'b0, 1'b0, "R8 restarted window");
      // clear coinciding with an unstable window's done cycle
      feed_window(LO_OVR - 1, 1'b0, 1'b1, "R8 clear wins over set R6");
      chk("R8 flag stays low", int'(err), 0);
   endtask

   task automatic t_extremes;
      feed_window(N, 1'b0, 1'b0, "R10 all ones");
      feed_window(0, 1'b0, 1'b1, "R10 all zeros");
   endtask

   task automatic t_hold;
      int c0;
      int s0;
      c0 = int'(cnt);
      s0 = int'(status);
      for (int j = 0; j < 50; j++) begin
         @(negedge clk);
         valid = 1'b0;
         bit_in = j[0];
      end
      chk("R9 count held", int'(cnt), c0);
      chk("R9 class held", int'(status), s0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_in_range();
      t_pos_over();
      t_neg_over();
      t_unstable_sticky();
      t_clear();
      t_extremes();
      t_hold();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule